// File: doc/BRIEF.md
# Split Instruction/Data Address Translation Unit

This block turns a virtual address into a physical address using two small direct-mapped tables. One table describes pages that code may be fetched from. The other describes pages that data may be loaded from or stored to. Every request reads both tables at the same index, which comes from the low page-number bits of the virtual address. The two selected entries are merged into one translation. That translation gives a physical address, a three-bit rights mask and an exception code.

Each table entry is a pair of 32-bit registers. The match register carries the virtual page tag and a valid bit. The translate register carries the physical page and six privilege-qualified permission bits. Software fills entries through a single write port.

A request has an access kind (fetch, load or store), a supervisor flag and a translation-enable flag. The result is registered and appears one cycle after the request. When a request faults, the unit raises a one-cycle strobe. It also captures the faulting virtual address and drops any pending load-linked reservation.

Top module: `split_tlb_xlat`

## Requirements
- R1: The table index is `va[18:13]` (8 KiB pages, 64 entries per table), and it selects one instruction entry and one data entry. A write (`wr_tbl` 0 = instruction, 1 = data; `wr_sel` 0 = match, 1 = translate) changes the entry at the next clock edge. A lookup in the same cycle still sees the old contents.
- R2: Bits [31:13] of a translate register hold its physical page. If the instruction and data physical pages of the selected entries differ, a fetch treats the data entry as all zeros. A load or store treats the instruction entry as all zeros.
- R3: A table matches when bits [31:13] of its match register equal `va[31:13]`. Bit 0 of the match register is the valid bit. A valid instruction match allows execute. A valid data match allows read and write.
- R4: The rights mask encoding is bit 0 read, bit 1 write, bit 2 execute. Translate register bits are: 0 user read, 1 user write, 2 supervisor read, 3 supervisor write, 4 user execute, 5 supervisor execute. The execute right comes from the instruction translate register. The read and write rights come from the data translate register. Each right uses the bit for the current privilege and is ANDed with the valid mask.
- R5: The physical address is the OR of both translate page fields (after the R2 pruning), concatenated with `va[12:0]`.
- R6: The needed right is execute for a fetch (`req_kind` 0), write for a store (2), and read for a load (1) or for code 3. If the needed right is in the rights mask, `rsp_exc` is 0 (none).
- R7: When the needed right is missing, the exception code is chosen as follows. If the valid mask covers the needed right, the code is 3 for a fetch (instruction page fault) or 4 otherwise (data page fault). If it does not, the code is 1 for a fetch (instruction miss) or 2 otherwise (data miss).
- R8: With `xlat_en` low, the physical address equals the virtual address, the rights mask is 3'b111 and the code is 0, whatever the table contents.
- R9: `fault_stb` is high for exactly the response cycles whose code is nonzero. `fault_va` then holds that request's virtual address, and it otherwise keeps its value.
- R10: A cycle with `ll_set` high sets `ll_valid` at the next edge. A fault clears it, and the clear wins over a set in the same cycle.
- R11: After reset, every entry is zero and all outputs are zero. An enabled lookup therefore misses.
- R12: `rsp_valid` and all results appear exactly one clock after the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 treated as load |
| req_sup | input | 1 | Supervisor privilege |
| xlat_en | input | 1 | Translation enable |
| ll_set | input | 1 | Set the load-linked reservation |
| wr_en | input | 1 | Table write strobe |
| wr_tbl | input | 1 | 0 instruction table, 1 data table |
| wr_sel | input | 1 | 0 match register, 1 translate register |
| wr_idx | input | 6 | Entry index to write |
| wr_data | input | 32 | Value written |
| rsp_valid | output | 1 | Result valid |
| rsp_pa | output | 32 | Physical address |
| rsp_rights | output | 3 | Rights mask (read, write, execute) |
| rsp_exc | output | 3 | Exception code |
| fault_stb | output | 1 | One-cycle fault pulse |
| fault_va | output | 32 | Captured faulting virtual address |
| ll_valid | output | 1 | Load-linked reservation pending |

## Verification
The first sweep walks all 64 permission patterns against all four valid-bit combinations, under both privileges and all three access kinds. This separates grants from page faults, page faults from misses, and user bits from supervisor bits. Single-bit tag mismatches in either table show that the comparison covers the whole page number and that a miss is reported against the right table. Entries whose physical pages disagree exercise the pruning rule, which flips with the access kind. Runs with translation disabled, and with a write landing in the same cycle as a lookup, cover the pass-through path and the update timing.

// File: rtl/stlb_pkg.sv
package stlb_pkg;

    typedef enum logic [2:0] {
        EXC_NONE  = 3'd0,
        EXC_IMISS = 3'd1,
        EXC_DMISS = 3'd2,
        EXC_IPF   = 3'd3,
        EXC_DPF   = 3'd4
    } exc_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    // permission bits inside a translate register
    localparam int unsigned RB_UR = 0;
    localparam int unsigned RB_UW = 1;
    localparam int unsigned RB_SR = 2;
    localparam int unsigned RB_SW = 3;
    localparam int unsigned RB_UX = 4;
    localparam int unsigned RB_SX = 5;

    // positions in the rights mask
    localparam int unsigned PERM_R = 0;
    localparam int unsigned PERM_W = 1;
    localparam int unsigned PERM_X = 2;

endpackage

// File: rtl/stlb_table.sv
module stlb_table #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              wsel,
    input  logic [IDX_W-1:0]  widx,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [ADDR_W-1:0] rmatch,
    output logic [ADDR_W-1:0] rxlat
);
    localparam int unsigned ENTRIES = 1 << IDX_W;

    logic [ADDR_W-1:0] match_q [ENTRIES];
    logic [ADDR_W-1:0] xlat_q  [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                match_q[i] <= '0;
                xlat_q[i]  <= '0;
            end
        end else if (we) begin
            if (wsel) xlat_q[widx]  <= wdata;
            else      match_q[widx] <= wdata;
        end
    end

    assign rmatch = match_q[ridx];
    assign rxlat  = xlat_q[ridx];

endmodule

// File: rtl/stlb_lookup.sv
module stlb_lookup
    import stlb_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_OFF_W = 13
) (
    input  logic [ADDR_W-1:0] va,
    input  logic [1:0]        acc,
    input  logic              sup,
    input  logic [ADDR_W-1:0] imr_i,
    input  logic [ADDR_W-1:0] itr_i,
    input  logic [ADDR_W-1:0] dmr_i,
    input  logic [ADDR_W-1:0] dtr_i,
    output logic [ADDR_W-1:0] pa,
    output logic [2:0]        rights,
    output logic [2:0]        exc
);
    logic [ADDR_W-1:0] imr, itr, dmr, dtr;
    logic              is_fetch;
    logic [2:0]        need, match_m, valid_m, grant;
    logic              unused_low;

    assign unused_low = ^{imr[PAGE_OFF_W-1:1], dmr[PAGE_OFF_W-1:1],
                          itr[PAGE_OFF_W-1:0], dtr[PAGE_OFF_W-1:0]};

    always_comb begin
        is_fetch = (acc == ACC_FETCH);
        imr = imr_i;
        itr = itr_i;
        dmr = dmr_i;
        dtr = dtr_i;
        // keep only the entry that serves this access when pages disagree
        if (itr_i[ADDR_W-1:PAGE_OFF_W] != dtr_i[ADDR_W-1:PAGE_OFF_W]) begin
            if (is_fetch) begin
                dmr = '0;
                dtr = '0;
            end else begin
                imr = '0;
                itr = '0;
            end
        end

        match_m         = '0;
        match_m[PERM_X] = (imr[ADDR_W-1:PAGE_OFF_W] == va[ADDR_W-1:PAGE_OFF_W]);
        match_m[PERM_R] = (dmr[ADDR_W-1:PAGE_OFF_W] == va[ADDR_W-1:PAGE_OFF_W]);
        match_m[PERM_W] = match_m[PERM_R];

        valid_m         = '0;
        valid_m[PERM_X] = imr[0];
        valid_m[PERM_R] = dmr[0];
        valid_m[PERM_W] = dmr[0];
        valid_m         = valid_m & match_m;

        grant         = '0;
        grant[PERM_X] = sup ? itr[RB_SX] : itr[RB_UX];
        grant[PERM_R] = sup ? dtr[RB_SR] : dtr[RB_UR];
        grant[PERM_W] = sup ? dtr[RB_SW] : dtr[RB_UW];
        grant         = grant & valid_m;

        need = '0;
        unique case (acc)
            ACC_FETCH: need[PERM_X] = 1'b1;
            ACC_STORE: need[PERM_W] = 1'b1;
            default:   need[PERM_R] = 1'b1;
        endcase

        pa     = {itr[ADDR_W-1:PAGE_OFF_W] | dtr[ADDR_W-1:PAGE_OFF_W],
                  va[PAGE_OFF_W-1:0]};
        rights = grant;

        if ((need & grant) != '0)        exc = EXC_NONE;
        else if ((need & valid_m) != '0) exc = is_fetch ? EXC_IPF : EXC_DPF;
        else                             exc = is_fetch ? EXC_IMISS : EXC_DMISS;
    end

endmodule

// File: rtl/split_tlb_xlat.sv
module split_tlb_xlat
    import stlb_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_OFF_W = 13,
    parameter int unsigned IDX_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_va,
    input  logic [1:0]        req_kind,
    input  logic              req_sup,
    input  logic              xlat_en,
    input  logic              ll_set,
    input  logic              wr_en,
    input  logic              wr_tbl,
    input  logic              wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_pa,
    output logic [2:0]        rsp_rights,
    output logic [2:0]        rsp_exc,
    output logic              fault_stb,
    output logic [ADDR_W-1:0] fault_va,
    output logic              ll_valid
);
    localparam int unsigned NTBL   = 2;
    localparam int unsigned IDX_LO = PAGE_OFF_W;
    localparam int unsigned IDX_HI = PAGE_OFF_W + IDX_W - 1;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] pa;
        logic [2:0]        rights;
        logic [2:0]        exc;
        logic              stb;
        logic [ADDR_W-1:0] fva;
        logic              llv;
    } state_t;

    state_t st_d, st_q;

    logic [ADDR_W-1:0] mr_rd [NTBL];
    logic [ADDR_W-1:0] tr_rd [NTBL];
    logic [IDX_W-1:0]  rd_idx;
    logic [ADDR_W-1:0] lk_pa;
    logic [2:0]        lk_rights, lk_exc;

    assign rd_idx = req_va[IDX_HI:IDX_LO];

    generate
        for (genvar g = 0; g < NTBL; g++) begin : g_tbl
            stlb_table #(
                .ADDR_W (ADDR_W),
                .IDX_W  (IDX_W)
            ) u_tbl (
                .clk    (clk),
                .rst_n  (rst_n),
                .we     (wr_en && (int'(wr_tbl) == g)),
                .wsel   (wr_sel),
                .widx   (wr_idx),
                .wdata  (wr_data),
                .ridx   (rd_idx),
                .rmatch (mr_rd[g]),
                .rxlat  (tr_rd[g])
            );
        end
    endgenerate

    stlb_lookup #(
        .ADDR_W     (ADDR_W),
        .PAGE_OFF_W (PAGE_OFF_W)
    ) u_lookup (
        .va     (req_va),
        .acc    (req_kind),
        .sup    (req_sup),
        .imr_i  (mr_rd[0]),
        .itr_i  (tr_rd[0]),
        .dmr_i  (mr_rd[1]),
        .dtr_i  (tr_rd[1]),
        .pa     (lk_pa),
        .rights (lk_rights),
        .exc    (lk_exc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        st_d.stb = 1'b0;
        st_d.exc = EXC_NONE;
        if (req_valid) begin
            if (xlat_en) begin
                st_d.pa     = lk_pa;
                st_d.rights = lk_rights;
                st_d.exc    = lk_exc;
                st_d.stb    = (lk_exc != EXC_NONE);
            end else begin
                st_d.pa     = req_va;
                st_d.rights = 3'b111;
            end
        end
        if (st_d.stb) begin
            st_d.fva = req_va;
            st_d.llv = 1'b0;
        end else if (ll_set) begin
            st_d.llv = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid  = st_q.vld;
    assign rsp_pa     = st_q.pa;
    assign rsp_rights = st_q.rights;
    assign rsp_exc    = st_q.exc;
    assign fault_stb  = st_q.stb;
    assign fault_va   = st_q.fva;
    assign ll_valid   = st_q.llv;

endmodule

// File: rtl/split_tlb_xlat_chk.sv
module split_tlb_xlat_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_va,
    input logic              xlat_en,
    input logic              ll_set,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_pa,
    input logic [2:0]        rsp_rights,
    input logic [2:0]        rsp_exc,
    input logic              fault_stb,
    input logic [ADDR_W-1:0] fault_va,
    input logic              ll_valid
);
    p_rsp_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_off_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlat_en) |=>
            (rsp_exc == 3'd0 && rsp_rights == 3'b111 && rsp_pa == $past(req_va)));

    p_strobe_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_stb == (rsp_exc != 3'd0));

    p_fault_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!fault_stb || fault_va == $past(req_va)));

    p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_stb |-> $stable(fault_va));

    p_code_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_exc <= 3'd4);

    p_resv_kill_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_stb |-> !ll_valid);

    p_resv_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ll_set |=> (ll_valid != fault_stb));

endmodule

bind split_tlb_xlat split_tlb_xlat_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_va     (req_va),
    .xlat_en    (xlat_en),
    .ll_set     (ll_set),
    .rsp_valid  (rsp_valid),
    .rsp_pa     (rsp_pa),
    .rsp_rights (rsp_rights),
    .rsp_exc    (rsp_exc),
    .fault_stb  (fault_stb),
    .fault_va   (fault_va),
    .ll_valid   (ll_valid)
);

// File: tb/split_tlb_xlat_bench.sv
`timescale 1ns/1ps
module split_tlb_xlat_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [1:0]  req_kind = '0;
    logic        req_sup = 1'b0;
    logic        xlat_en = 1'b0;
    logic        ll_set = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_tbl = 1'b0;
    logic        wr_sel = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic [2:0]  rsp_rights;
    logic [2:0]  rsp_exc;
    logic        fault_stb;
    logic [31:0] fault_va;
    logic        ll_valid;

    always #2 clk = ~clk;

    split_tlb_xlat u_split_tlb_xlat (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_kind(req_kind), .req_sup(req_sup), .xlat_en(xlat_en), .ll_set(ll_set),
        .wr_en(wr_en), .wr_tbl(wr_tbl), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_data(wr_data), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_rights(rsp_rights), .rsp_exc(rsp_exc), .fault_stb(fault_stb),
        .fault_va(fault_va), .ll_valid(ll_valid)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [31:0] bmr [2][64];
    logic [31:0] btr [2][64];
    logic [31:0] exp_fva = '0;
    logic        exp_llv = 1'b0;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // expected translation from the requirements
    function automatic void model(input logic [31:0] va, input logic [1:0] k,
                                  input logic s, input logic en,
                                  output logic [31:0] pa, output logic [2:0] rt,
                                  output logic [2:0] ex);
        logic [31:0] imr, itr, dmr, dtr;
        logic [5:0]  ix;
        logic        vx, vd;
        logic [2:0]  need, vm;
        ix  = va[18:13];
        imr = bmr[0][ix]; itr = btr[0][ix];
        dmr = bmr[1][ix]; dtr = btr[1][ix];
        if (itr[31:13] != dtr[31:13]) begin
            if (k == 2'd0) begin dmr = 0; dtr = 0; end
            else           begin imr = 0; itr = 0; end
        end
        vx = imr[0] && (imr[31:13] == va[31:13]);
        vd = dmr[0] && (dmr[31:13] == va[31:13]);
        vm = {vx, vd, vd};
        rt[2] = vx && (s ? itr[5] : itr[4]);
        rt[1] = vd && (s ? dtr[3] : dtr[1]);
        rt[0] = vd && (s ? dtr[2] : dtr[0]);
        need = (k == 2'd0) ? 3'b100 : (k == 2'd2) ? 3'b010 : 3'b001;
        pa = {itr[31:13] | dtr[31:13], va[12:0]};
        if (!en) begin
            pa = va; rt = 3'b111; ex = 3'd0;
        end else if ((need & rt) != 0) ex = 3'd0;
        else if ((need & vm) != 0)     ex = (k == 2'd0) ? 3'd3 : 3'd4;
        else                           ex = (k == 2'd0) ? 3'd1 : 3'd2;
    endfunction

    // all tasks start and end just after a falling edge
    task automatic wr(input logic t, input logic sel, input logic [5:0] ix,
                      input logic [31:0] d);
        wr_en = 1'b1; wr_tbl = t; wr_sel = sel; wr_idx = ix; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) btr[t][ix] = d; else bmr[t][ix] = d;
    endtask

    task automatic do_req(input string grp, input logic [31:0] va,
                          input logic [1:0] k, input logic s, input logic en);
        logic [31:0] epa;
        logic [2:0]  ert, eex;
        logic        estb;
        req_valid = 1'b1; req_va = va; req_kind = k; req_sup = s; xlat_en = en;
        model(va, k, s, en, epa, ert, eex);
        estb = (eex != 3'd0);
        if (estb) exp_fva = va;
        exp_llv = estb ? 1'b0 : (ll_set ? 1'b1 : exp_llv);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12", "rsp_valid", 64'(rsp_valid), 64'(1'b1));
        chk("R5", "pa", 64'(rsp_pa), 64'(epa));
        chk("R4", "rights", 64'(rsp_rights), 64'(ert));
        chk(eex == 3'd0 ? "R6" : "R7", "exc", 64'(rsp_exc), 64'(eex));
        chk("R9", "fault_stb", 64'(fault_stb), 64'(estb));
        chk("R9", "fault_va", 64'(fault_va), 64'(exp_fva));
        chk("R10", "ll_valid", 64'(ll_valid), 64'(exp_llv));
        chk(grp, "result", {26'd0, rsp_pa, rsp_rights, rsp_exc}, {26'd0, epa, ert, eex});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < 64; i++) begin bmr[t][i] = 0; btr[t][i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state and an empty table
        chk("R11", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R11", "pa", 64'(rsp_pa), 64'd0);
        chk("R11", "exc", 64'(rsp_exc), 64'd0);
        chk("R11", "fault_va", 64'(fault_va), 64'd0);
        chk("R11", "ll_valid", 64'(ll_valid), 64'd0);
        do_req("R11", 32'h1234_5678, 2'd1, 1'b0, 1'b1);
        chk("R11", "empty load misses", 64'(rsp_exc), 64'd2);
        do_req("R11", 32'h0000_0010, 2'd0, 1'b1, 1'b1);

        // R4 / R6 / R7: every permission pattern with every valid pairing
        for (int rr = 0; rr < 64; rr++) begin
            for (int vi = 0; vi < 4; vi++) begin
                logic [18:0] vp, pp;
                logic [31:0] va;
                vp = {13'(rr + 3), 6'(rr)};
                pp = 19'(rr * 977 + 11 + vi);
                va = {vp, 13'h0A5 ^ 13'(rr)};
                wr(1'b0, 1'b0, 6'(rr), {vp, 12'd0, vi[0]});
                wr(1'b1, 1'b0, 6'(rr), {vp, 12'd0, vi[1]});
                wr(1'b0, 1'b1, 6'(rr), {pp, 7'd0, 6'(rr)});
                wr(1'b1, 1'b1, 6'(rr), {pp, 7'd0, 6'(rr)});
                for (int s = 0; s < 2; s++)
                    for (int k = 0; k < 3; k++)
                        do_req("R4", va, 2'(k), s[0], 1'b1);
            end
        end

        // R3: one tag bit flipped in one table
        for (int i = 0; i < 19; i++) begin
            logic [18:0] vp;
            logic [31:0] va;
            vp = {13'(i * 37 + 1), 6'(i)};
            va = {vp, 13'(i * 101)};
            wr(1'b0, 1'b0, 6'(i), {(i % 2 == 0) ? vp ^ 19'(1 << i) : vp, 12'd0, 1'b1});
            wr(1'b1, 1'b0, 6'(i), {(i % 2 == 1) ? vp ^ 19'(1 << i) : vp, 12'd0, 1'b1});
            wr(1'b0, 1'b1, 6'(i), {19'h0_4400, 13'h3F});
            wr(1'b1, 1'b1, 6'(i), {19'h0_4400, 13'h3F});
            for (int k = 0; k < 3; k++)
                do_req("R3", va, 2'(k), 1'b1, 1'b1);
        end

        // R2: disagreeing physical pages, pruning depends on access kind
        for (int i = 20; i < 28; i++) begin
            logic [18:0] vp;
            logic [31:0] va;
            vp = {13'(i), 6'(i)};
            va = {vp, 13'h1FFF};
            wr(1'b0, 1'b0, 6'(i), {vp, 12'd0, 1'b1});
            wr(1'b1, 1'b0, 6'(i), {vp, 12'd0, (i % 3 != 0)});
            wr(1'b0, 1'b1, 6'(i), {19'h5_0000 | 19'(i), 13'h30});
            wr(1'b1, 1'b1, 6'(i), {19'h0_A000 | 19'(i << 4), 13'(i % 16)});
            for (int s = 0; s < 2; s++)
                for (int k = 0; k < 4; k++)
                    do_req("R2", va, 2'(k), s[0], 1'b1);
        end
        do_req("R2", {13'd20, 6'd20, 13'd0}, 2'd0, 1'b0, 1'b1);
        chk("R2", "fetch keeps instruction page", 64'(rsp_pa), 64'({19'h5_0014, 13'd0}));

        // R8: translation disabled passes the address through
        for (int i = 0; i < 24; i++)
            do_req("R8", 32'h9E37_79B9 * 32'(i + 1), 2'(i % 4), i[0], 1'b0);

        // R1: index selection and write timing
        wr(1'b1, 1'b0, 6'd40, {13'h0777, 6'd40, 12'd0, 1'b1});
        wr(1'b1, 1'b1, 6'd40, {19'h1_2340, 13'h0F});
        wr(1'b0, 1'b1, 6'd40, {19'h1_2340, 13'h00});
        do_req("R1", {13'h0777, 6'd40, 13'h0123}, 2'd1, 1'b0, 1'b1);
        chk("R1", "hit at selected index", 64'(rsp_exc), 64'd0);
        do_req("R1", {13'h0777, 6'd41, 13'h0123}, 2'd1, 1'b0, 1'b1);
        wr(1'b0, 1'b1, 6'd50, {19'h0_0ABC, 13'h30});
        wr_en = 1'b1; wr_tbl = 1'b0; wr_sel = 1'b0; wr_idx = 6'd50;
        wr_data = {13'h0555, 6'd50, 12'd0, 1'b1};
        do_req("R1", {13'h0555, 6'd50, 13'h0004}, 2'd0, 1'b1, 1'b1);
        chk("R1", "same-cycle write not seen", 64'(rsp_exc), 64'd1);
        wr_en = 1'b0;
        bmr[0][50] = {13'h0555, 6'd50, 12'd0, 1'b1};
        do_req("R1", {13'h0555, 6'd50, 13'h0004}, 2'd0, 1'b1, 1'b1);
        chk("R1", "write seen next cycle", 64'(rsp_exc), 64'd0);

        // R10: reservation set, cleared by fault, clear beats set
        ll_set = 1'b1;
        do_req("R10", {13'h0777, 6'd40, 13'h0001}, 2'd1, 1'b0, 1'b1);
        ll_set = 1'b0;
        chk("R10", "set by ll_set", 64'(ll_valid), 64'd1);
        do_req("R10", {13'h0777, 6'd40, 13'h0002}, 2'd2, 1'b0, 1'b1);
        do_req("R10", {13'h0777, 6'd40, 13'h0003}, 2'd0, 1'b0, 1'b1);
        chk("R10", "cleared by fault", 64'(ll_valid), 64'd0);
        ll_set = 1'b1;
        do_req("R10", {13'h0111, 6'd60, 13'h0003}, 2'd1, 1'b0, 1'b1);
        ll_set = 1'b0;
        chk("R10", "fault wins over set", 64'(ll_valid), 64'd0);

        // R9 / R12: idle cycle gives no response and keeps the address
        @(negedge clk);
        chk("R12", "idle rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R9", "idle fault_stb", 64'(fault_stb), 64'd0);
        chk("R9", "idle fault_va", 64'(fault_va), 64'(exp_fva));

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule